// File: doc/BRIEF.md
# Chip Erase-and-Verify Sequencer

This block runs the whole-array electrical erase flow of a reprogrammable byte-wide memory. When it receives a start command, it first writes zero into every location through a simple program strobe. This leaves all cells in a known state. It then holds an erase pulse of fixed length, and for the whole pulse it raises a request for the high-voltage level on the erase-select line. After that it reads the array back and checks that every location holds all ones.

If a location does not read as erased, the verify sweep stops at that address. The sequencer then fires another erase pulse and starts a new verify from address zero. The number of erase pulses is bounded. When the bound is used up without a clean verify, the run ends as a device failure. A clean verify ends the run as a pass.

The memory's cell behaviour and the generation of the high voltage are outside the block. The sequencer only drives the strobes and the request flag, and it samples the read data one cycle after it presents an address. The pulse lengths, the array depth and the attempt limit are all parameters, so a short run can be used in simulation.

Top module: `erase_seq`

## Requirements
- R1: While reset is held and afterwards until a start arrives, `ce_n_o`, `oe_n_o` and `prog_n_o` are 1, and `hv_req_o`, `done_o`, `pass_o` and `fail_o` are 0.
- R2: After a start, each address from 0 up to DEPTH-1 is programmed in ascending order, with `mem_wdata_o` = 0x00. A program cycle has `ce_n_o`=0, `prog_n_o`=0 and `hv_req_o`=0, and each address gets exactly PGM_CYC such cycles. All of this happens before the first cycle with `hv_req_o`=1, and no program cycle follows it.
- R3: Every erase pulse is a run of exactly ERASE_CYC consecutive cycles with `hv_req_o`=1. Throughout the run `prog_n_o`=0, `ce_n_o`=0 and `oe_n_o`=1.
- R4: The verify sweep runs with `hv_req_o`=0, `ce_n_o`=0, `oe_n_o`=0 and `prog_n_o`=1. It starts at address 0 and ascends. Each address is held for exactly two cycles, and the read data is compared against 0xFF in the second of them, one cycle after the address appears.
- R5: The first address that does not read 0xFF ends the sweep, and no later address is read. The next erase pulse begins in the following cycle.
- R6: If the verify after erase pulse number MAX_TRY fails, the run ends with `fail_o`=1 and `pass_o`=0. No more than MAX_TRY pulses are issued per run.
- R7: A sweep in which every address reads 0xFF ends the run with `pass_o`=1 and `fail_o`=0.
- R8: `done_o`, `pass_o` and `fail_o` hold their values until the next start. A start that arrives during a run is ignored.
- R9: `pass_o` and `fail_o` are never 1 together, and `hv_req_o` is never 1 while `oe_n_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin an erase run (sampled when idle or done) |
| mem_addr_o | output | $clog2(DEPTH) | Address presented to the memory |
| mem_wdata_o | output | 8 | Program data (always zero) |
| mem_rdata_i | input | 8 | Registered read data from the memory |
| ce_n_o | output | 1 | Chip enable, active low |
| oe_n_o | output | 1 | Output enable, active low |
| prog_n_o | output | 1 | Program/erase strobe, active low |
| hv_req_o | output | 1 | Request high voltage on the erase-select line |
| done_o | output | 1 | Run finished |
| pass_o | output | 1 | Run finished with a clean verify |
| fail_o | output | 1 | Run finished after the attempt limit |

## Verification
The bench gives every location a private count of pulses it needs before it reads erased, so the index of the first failing location moves from attempt to attempt. If a design scanned past a failing address, or restarted its sweep anywhere other than zero, the number of read cycles would not match the count predicted from those pulse needs. Three limit cases check the pulse budget: a cell that clears on exactly the last allowed pulse, one that needs a single pulse more, and one that never clears. An off-by-one in the attempt count would pass the second case or fail the first. The monitors also track the order of the pre-program sweep against the first erase pulse, the length of every pulse, and a stray start issued in the middle of a run. A design that skipped pre-programming, cut a pulse short, or restarted on the stray start would change these observed counts.

// File: rtl/erase_pkg.sv
package erase_pkg;

    localparam int DATA_W = 8;
    localparam logic [DATA_W-1:0] ERASED_BYTE = '1;
    localparam logic [DATA_W-1:0] ZERO_BYTE   = '0;

    typedef enum logic [2:0] {
        S_IDLE,
        S_PGM_SET,
        S_PGM_STRB,
        S_ERASE,
        S_VFY_ADDR,
        S_VFY_CHK,
        S_DONE
    } seq_state_t;

    typedef struct packed {
        logic ce_n;
        logic oe_n;
        logic prog_n;
        logic hv;
    } mem_ctl_t;

    function automatic logic byte_is_erased(input logic [DATA_W-1:0] d);
        return d == ERASED_BYTE;
    endfunction

    function automatic mem_ctl_t ctl_of(input seq_state_t s);
        mem_ctl_t c;
        c = '{ce_n: 1'b1, oe_n: 1'b1, prog_n: 1'b1, hv: 1'b0};
        case (s)
            S_PGM_SET:  c = '{ce_n: 1'b0, oe_n: 1'b1, prog_n: 1'b1, hv: 1'b0};
            S_PGM_STRB: c = '{ce_n: 1'b0, oe_n: 1'b1, prog_n: 1'b0, hv: 1'b0};
            S_ERASE:    c = '{ce_n: 1'b0, oe_n: 1'b1, prog_n: 1'b0, hv: 1'b1};
            S_VFY_ADDR,
            S_VFY_CHK:  c = '{ce_n: 1'b0, oe_n: 1'b0, prog_n: 1'b1, hv: 1'b0};
            default:    c = '{ce_n: 1'b1, oe_n: 1'b1, prog_n: 1'b1, hv: 1'b0};
        endcase
        return c;
    endfunction

endpackage

// File: rtl/erase_counter.sv
module erase_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr_i,
    input  logic         inc_i,
    input  logic [W-1:0] lim_i,
    output logic [W-1:0] cnt_o,
    output logic         hit_o
);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            cnt_q <= '0;
        end else if (inc_i) begin
            cnt_q <= cnt_q + W'(1);
        end
    end

    assign cnt_o = cnt_q;
    assign hit_o = (cnt_q == lim_i);

endmodule

// File: rtl/erase_fsm.sv
module erase_fsm
    import erase_pkg::*;
#(
    parameter int TW        = 8,
    parameter int PGM_CYC   = 4,
    parameter int ERASE_CYC = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [DATA_W-1:0] rdata_i,
    input  logic              tmr_hit_i,
    input  logic              addr_last_i,
    input  logic              try_hit_i,
    output logic              tmr_clr_o,
    output logic              tmr_inc_o,
    output logic [TW-1:0]     tmr_lim_o,
    output logic              addr_clr_o,
    output logic              addr_inc_o,
    output logic              try_clr_o,
    output logic              try_inc_o,
    output mem_ctl_t          ctl_o,
    output logic              done_o,
    output logic              pass_o,
    output logic              fail_o
);

    localparam logic [TW-1:0] PGM_LIM   = TW'(PGM_CYC - 1);
    localparam logic [TW-1:0] ERASE_LIM = TW'(ERASE_CYC - 1);

    seq_state_t state_q, state_d;
    logic       done_q, pass_q, fail_q;
    logic       set_done, set_pass, clr_status;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= S_IDLE;
            done_q  <= 1'b0;
            pass_q  <= 1'b0;
            fail_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (clr_status) begin
                done_q <= 1'b0;
                pass_q <= 1'b0;
                fail_q <= 1'b0;
            end else if (set_done) begin
                done_q <= 1'b1;
                pass_q <= set_pass;
                fail_q <= !set_pass;
            end
        end
    end

    always_comb begin
        state_d    = state_q;
        tmr_clr_o  = 1'b0;
        tmr_inc_o  = 1'b0;
        tmr_lim_o  = PGM_LIM;
        addr_clr_o = 1'b0;
        addr_inc_o = 1'b0;
        try_clr_o  = 1'b0;
        try_inc_o  = 1'b0;
        set_done   = 1'b0;
        set_pass   = 1'b0;
        clr_status = 1'b0;
        case (state_q)
            S_IDLE, S_DONE: begin
                if (start_i) begin
                    state_d    = S_PGM_SET;
                    addr_clr_o = 1'b1;
                    try_clr_o  = 1'b1;
                    tmr_clr_o  = 1'b1;
                    clr_status = 1'b1;
                end
            end
            S_PGM_SET: begin
                tmr_clr_o = 1'b1;
                state_d   = S_PGM_STRB;
            end
            S_PGM_STRB: begin
                tmr_lim_o = PGM_LIM;
                if (tmr_hit_i) begin
                    tmr_clr_o = 1'b1;
                    if (addr_last_i) begin
                        state_d = S_ERASE;
                    end else begin
                        addr_inc_o = 1'b1;
                        state_d    = S_PGM_SET;
                    end
                end else begin
                    tmr_inc_o = 1'b1;
                end
            end
            S_ERASE: begin
                tmr_lim_o = ERASE_LIM;
                if (tmr_hit_i) begin
                    tmr_clr_o  = 1'b1;
                    try_inc_o  = 1'b1;
                    addr_clr_o = 1'b1;
                    state_d    = S_VFY_ADDR;
                end else begin
                    tmr_inc_o = 1'b1;
                end
            end
            S_VFY_ADDR: begin
                state_d = S_VFY_CHK;
            end
            S_VFY_CHK: begin
                if (!byte_is_erased(rdata_i)) begin
                    if (try_hit_i) begin
                        set_done = 1'b1;
                        state_d  = S_DONE;
                    end else begin
                        tmr_clr_o = 1'b1;
                        state_d   = S_ERASE;
                    end
                end else if (addr_last_i) begin
                    set_done = 1'b1;
                    set_pass = 1'b1;
                    state_d  = S_DONE;
                end else begin
                    addr_inc_o = 1'b1;
                    state_d    = S_VFY_ADDR;
                end
            end
            default: state_d = S_IDLE;
        endcase
    end

    assign ctl_o  = ctl_of(state_q);
    assign done_o = done_q;
    assign pass_o = pass_q;
    assign fail_o = fail_q;

    AST_DONE_HOLD: assert property (@(posedge clk) disable iff (rst)
        done_o && !start_i |=> done_o && $stable(pass_o) && $stable(fail_o)); // R8
    AST_PASS_FAIL_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(pass_o && fail_o)); // R9
    AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_ERASE) && start_i && !tmr_hit_i |=> state_q == S_ERASE); // R8
    AST_VFY_MISS_REERASE: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_VFY_CHK) && !byte_is_erased(rdata_i) && !try_hit_i |=> ctl_o.hv); // R5

endmodule

// File: rtl/erase_seq.sv
module erase_seq
    import erase_pkg::*;
#(
    parameter int DEPTH     = 131072,
    parameter int PGM_CYC   = 1250,
    parameter int ERASE_CYC = 25000000,
    parameter int MAX_TRY   = 200,
    localparam int AW       = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    output logic [AW-1:0]     mem_addr_o,
    output logic [DATA_W-1:0] mem_wdata_o,
    input  logic [DATA_W-1:0] mem_rdata_i,
    output logic              ce_n_o,
    output logic              oe_n_o,
    output logic              prog_n_o,
    output logic              hv_req_o,
    output logic              done_o,
    output logic              pass_o,
    output logic              fail_o
);

    localparam int TMAX = (ERASE_CYC > PGM_CYC) ? ERASE_CYC : PGM_CYC;
    localparam int TW   = $clog2(TMAX + 1);
    localparam int CW   = $clog2(MAX_TRY + 1);
    localparam logic [AW-1:0] ADDR_LAST = AW'(DEPTH - 1);
    localparam logic [CW-1:0] TRY_LIM   = CW'(MAX_TRY);

    logic          tmr_clr, tmr_inc, tmr_hit;
    logic [TW-1:0] tmr_lim, tmr_cnt;
    logic          addr_clr, addr_inc, addr_hit;
    logic [AW-1:0] addr_cnt;
    logic          try_clr, try_inc, try_hit;
    logic [CW-1:0] try_cnt;
    mem_ctl_t      ctl;

    erase_counter #(.W(TW)) u_timer (
        .clk   (clk),
        .rst   (rst),
        .clr_i (tmr_clr),
        .inc_i (tmr_inc),
        .lim_i (tmr_lim),
        .cnt_o (tmr_cnt),
        .hit_o (tmr_hit)
    );

    erase_counter #(.W(AW)) u_addr (
        .clk   (clk),
        .rst   (rst),
        .clr_i (addr_clr),
        .inc_i (addr_inc),
        .lim_i (ADDR_LAST),
        .cnt_o (addr_cnt),
        .hit_o (addr_hit)
    );

    erase_counter #(.W(CW)) u_tries (
        .clk   (clk),
        .rst   (rst),
        .clr_i (try_clr),
        .inc_i (try_inc),
        .lim_i (TRY_LIM),
        .cnt_o (try_cnt),
        .hit_o (try_hit)
    );

    erase_fsm #(
        .TW        (TW),
        .PGM_CYC   (PGM_CYC),
        .ERASE_CYC (ERASE_CYC)
    ) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .start_i     (start_i),
        .rdata_i     (mem_rdata_i),
        .tmr_hit_i   (tmr_hit),
        .addr_last_i (addr_hit),
        .try_hit_i   (try_hit),
        .tmr_clr_o   (tmr_clr),
        .tmr_inc_o   (tmr_inc),
        .tmr_lim_o   (tmr_lim),
        .addr_clr_o  (addr_clr),
        .addr_inc_o  (addr_inc),
        .try_clr_o   (try_clr),
        .try_inc_o   (try_inc),
        .ctl_o       (ctl),
        .done_o      (done_o),
        .pass_o      (pass_o),
        .fail_o      (fail_o)
    );

    assign mem_addr_o  = addr_cnt;
    assign mem_wdata_o = ZERO_BYTE;
    assign ce_n_o      = ctl.ce_n;
    assign oe_n_o      = ctl.oe_n;
    assign prog_n_o    = ctl.prog_n;
    assign hv_req_o    = ctl.hv;

    AST_PGM_BEFORE_HV: assert property (@(posedge clk) disable iff (rst)
        $rose(hv_req_o) && (try_cnt == '0) |-> addr_hit); // R2
    AST_HV_END_ON_TIMER: assert property (@(posedge clk) disable iff (rst)
        $fell(hv_req_o) |-> $past(tmr_hit) && $past(tmr_cnt) == TW'(ERASE_CYC - 1)); // R3
    AST_VFY_NO_HV: assert property (@(posedge clk) disable iff (rst)
        !oe_n_o |-> !hv_req_o && prog_n_o && !ce_n_o); // R4
    AST_TRY_BOUND: assert property (@(posedge clk) disable iff (rst)
        try_cnt <= TRY_LIM); // R6
    AST_FAIL_AT_LIMIT: assert property (@(posedge clk) disable iff (rst)
        $rose(fail_o) |-> try_hit); // R6
    AST_IDLE_AFTER_RESET: assert property (@(posedge clk)
        $past(rst) |-> ce_n_o && oe_n_o && prog_n_o && !hv_req_o && !done_o); // R1

endmodule

// File: tb/erase_seq_tb_top.sv
module erase_seq_tb_top;

    localparam int DEPTH     = 16;
    localparam int PGM_CYC   = 2;
    localparam int ERASE_CYC = 8;
    localparam int MAX_TRY   = 200;
    localparam int AW        = $clog2(DEPTH);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [AW-1:0] addr;
    logic [7:0]    wdata;
    logic [7:0]    rdata = 8'h00;
    logic          ce_n, oe_n, prog_n, hv, done, pass_s, fail_s;

    int tests = 0;
    int fails = 0;
    longint cyc = 0;

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    erase_seq #(
        .DEPTH     (DEPTH),
        .PGM_CYC   (PGM_CYC),
        .ERASE_CYC (ERASE_CYC),
        .MAX_TRY   (MAX_TRY)
    ) dut_i (
        .clk         (clk),
        .rst         (rst),
        .start_i     (start),
        .mem_addr_o  (addr),
        .mem_wdata_o (wdata),
        .mem_rdata_i (rdata),
        .ce_n_o      (ce_n),
        .oe_n_o      (oe_n),
        .prog_n_o    (prog_n),
        .hv_req_o    (hv),
        .done_o      (done),
        .pass_o      (pass_s),
        .fail_o      (fail_s)
    );

    // pulses each location needs before it reads erased
    int   need [DEPTH];
    logic mon_clr = 1'b0;

    // memory model
    logic [7:0] mem [DEPTH];
    int m_run, m_pulses;
    always @(posedge clk) begin
        if (mon_clr) begin
            m_run = 0;
            m_pulses = 0;
            for (int i = 0; i < DEPTH; i++) mem[i] = 8'hA5;
        end else if (!ce_n) begin
            if (hv && !prog_n) begin
                m_run++;
                if (m_run == ERASE_CYC) begin
                    m_pulses++;
                    for (int i = 0; i < DEPTH; i++)
                        if (m_pulses >= need[i]) mem[i] = 8'hFF;
                end
            end else begin
                m_run = 0;
            end
            if (!hv && !prog_n) mem[addr] = mem[addr] & wdata;
            if (!oe_n) rdata <= mem[addr];
        end else begin
            m_run = 0;
        end
    end

    // port monitor
    int pgm_cnt [DEPTH];
    int rises, run, len_err, hvctl_err, pre_err, data_err, porder_err;
    int oe_cyc, vorder_err, last_pa;
    logic prev_hv, prev_oe;
    logic [AW-1:0] prev_a;
    always @(negedge clk) begin
        if (mon_clr) begin
            for (int i = 0; i < DEPTH; i++) pgm_cnt[i] = 0;
            rises = 0; run = 0; len_err = 0; hvctl_err = 0; pre_err = 0;
            data_err = 0; porder_err = 0; oe_cyc = 0; vorder_err = 0;
            last_pa = 0; prev_hv = 1'b0; prev_oe = 1'b0; prev_a = '0;
        end else begin
            if (hv) begin
                if (!prev_hv) begin
                    rises++;
                    if (rises == 1)
                        for (int i = 0; i < DEPTH; i++)
                            if (pgm_cnt[i] != PGM_CYC) pre_err++;
                end
                run++;
                if (prog_n || !oe_n || ce_n) hvctl_err++;
            end else if (prev_hv) begin
                if (run != ERASE_CYC) len_err++;
                run = 0;
            end
            if (!ce_n && !prog_n && !hv) begin
                pgm_cnt[addr]++;
                if (wdata != 8'h00) data_err++;
                if (int'(addr) < last_pa || rises != 0) porder_err++;
                last_pa = int'(addr);
            end
            if (!oe_n) begin
                oe_cyc++;
                if (hv) hvctl_err++;
                if (!prev_oe) begin
                    if (addr != '0) vorder_err++;
                end else if (addr != prev_a && addr != prev_a + AW'(1)) begin
                    vorder_err++;
                end
            end
            prev_hv = hv;
            prev_oe = !oe_n;
            prev_a  = addr;
        end
    end

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // expected results from the pulse needs
    int  exp_tries, exp_oe;
    bit  exp_pass;
    task automatic predict();
        int mx = 0;
        for (int i = 0; i < DEPTH; i++) if (need[i] > mx) mx = need[i];
        exp_pass  = (mx <= MAX_TRY);
        exp_tries = exp_pass ? mx : MAX_TRY;
        exp_oe = 0;
        for (int a = 1; a <= exp_tries; a++) begin
            int rd = DEPTH;
            for (int i = DEPTH - 1; i >= 0; i--) if (need[i] > a) rd = i + 1;
            exp_oe += 2 * rd;
        end
    endtask

    task automatic run_case(input string name, input bit inject);
        int n = 0;
        predict();
        @(posedge clk); #1 mon_clr = 1'b1;
        @(posedge clk); #1 mon_clr = 1'b0; start = 1'b1;
        @(posedge clk); #1 start = 1'b0;
        if (inject) begin
            repeat (30) @(posedge clk);
            #1 start = 1'b1;
            @(posedge clk); #1 start = 1'b0;
        end
        @(negedge clk);
        while (!done && n < 20000) begin @(negedge clk); n++; end
        $display("[TB] case %s", name);
        chk("R7", "pass flag", pass_s, exp_pass);
        chk("R6", "fail flag", fail_s, !exp_pass);
        chk("R9", "pass and fail together", pass_s && fail_s, 0);
        chk("R6", "erase pulses seen", rises, exp_tries);
        chk("R3", "full-length pulses", m_pulses, exp_tries);
        chk("R3", "pulse length errors", len_err, 0);
        chk("R3", "strobe errors during pulse", hvctl_err, 0);
        chk("R2", "pre-program coverage errors", pre_err, 0);
        chk("R2", "program data/order errors", data_err + porder_err, 0);
        chk("R4", "verify order errors", vorder_err, 0);
        chk("R5", "verify read cycles", oe_cyc, exp_oe);
        repeat (10) @(negedge clk);
        chk("R8", "done held", done, 1);
        chk("R8", "pass held", pass_s, exp_pass);
    endtask

    initial begin : watchdog
        wait (cyc > 150000);
        fails++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin : main
        void'($urandom(32'd4813));
        for (int i = 0; i < DEPTH; i++) need[i] = 1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk("R1", "ce_n in reset", ce_n, 1);
        chk("R1", "hv in reset", hv, 0);
        #1 rst = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1", "oe_n/prog_n idle", {oe_n, prog_n}, 2'b11);
        chk("R1", "status idle", {done, pass_s, fail_s}, 3'b000);

        run_case("clean after one pulse", 1'b0);

        for (int i = 0; i < DEPTH; i++) need[i] = 1;
        need[DEPTH-1] = 3;
        run_case("last address slow, start injected", 1'b1);

        for (int i = 0; i < DEPTH; i++) need[i] = 1;
        need[0] = 4;
        run_case("first address slow", 1'b0);

        for (int k = 0; k < 3; k++) begin
            for (int i = 0; i < DEPTH; i++) need[i] = 1 + int'($urandom % 6);
            run_case("random needs", 1'b0);
        end

        for (int i = 0; i < DEPTH; i++) need[i] = 1;
        need[7] = MAX_TRY;
        run_case("clears on last allowed pulse", 1'b0);

        need[7] = MAX_TRY + 1;
        run_case("one pulse beyond limit", 1'b0);

        for (int i = 0; i < DEPTH; i++) need[i] = 1000;
        run_case("never clears", 1'b0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule